// File: doc/BRIEF.md
# Byte-Addressed SPI Register Slave

This block lets an external SPI master reach a bank of 16-bit registers through 16-bit full-duplex frames (clock idles high; data is captured on rising SCLK and launched on falling SCLK). Every register answers at two 6-bit addresses. The odd address selects its upper byte and the even address its lower byte. A write frame changes one byte. A read frame fetches the whole 16-bit register, and that value is shifted out during the following frame, so a stream of reads costs one extra frame in total.

All SPI pins are brought into the system clock domain through synchronisers, and their edges are detected there, so SCLK must run well below the system clock. The register storage sits outside the block. This block drives a byte write port and a register index for reading, and takes the read data back in. It keeps a new-data flag for each measurement register and puts that flag in bit 15 of the returned word. An alarm input goes into bit 14. The block also holds a small status register. It latches frames that end with the wrong clock count, and reading it clears the latch.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is accepted only when chip select goes low, exactly 16 SCLK rising edges occur, and chip select goes high again. Bits are taken MSB first on rising edges. Bit 15 = 1 with bit 14 = 0 means write, and bits 15:14 = 00 means read. Bits 13:8 carry the address and bits 7:0 carry the write data.
- R2: An accepted write whose target is writable produces one single-cycle `bank_wr_en` pulse with `bank_wr_idx` = address[5:1], `bank_wr_hi` = address[0] (1 = bits 15:8, 0 = bits 7:0) and `bank_wr_data` = frame bits 7:0. The other byte is left alone.
- R3: After an accepted read of either address of a register, the next frame shifts out that register's 16-bit word MSB first. Bit 15 is valid once chip select has fallen, and each later bit follows a falling SCLK edge.
- R4: While chip select is high, `spi_miso_oe` is 0, and SCLK and MOSI activity changes no state and causes no writes.
- R5: For measurement registers (indices 1 to 7, addresses 0x02 to 0x0F), the returned word is {new-data, alarm, bank bits 13:0}. A pulse on `data_upd[i]` sets the new-data flag of register i. Reading the register clears that flag.
- R6: A frame with any SCLK rising-edge count other than 16 is discarded (no write, next returned word 0x0000) and sets the failure flag.
- R7: The status register (index 30, addresses 0x3C and 0x3D) reads as 0x0008 when the failure flag is set and 0x0000 otherwise. Reading it clears the flag.
- R8: Writes to indices not marked writable (indices 0 to 9 and 30 by default) produce no `bank_wr_en` pulse.
- R9: After reset, `spi_miso_oe` and `bank_wr_en` are 0, all new-data flags and the failure flag are clear, and the first frame returns 0x0000.
- R10: The frame that follows a write, or follows a frame whose bits 15:14 are 11 or 01, returns 0x0000. A frame with bit 14 = 1 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idles high |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for `spi_miso` (0 = high impedance) |
| bank_wr_en | output | 1 | Byte write strobe to the register bank |
| bank_wr_idx | output | 5 | Register index of the write |
| bank_wr_hi | output | 1 | 1 = write bits 15:8, 0 = write bits 7:0 |
| bank_wr_data | output | 8 | Byte to write |
| bank_rd_idx | output | 5 | Register index being read |
| bank_rd_data | input | 16 | Register contents for `bank_rd_idx` |
| data_upd | input | 32 | One strobe per register marking fresh data |
| alarm | input | 1 | Alarm level reported in bit 14 of measurement words |

## Verification
The assertions assume that chip select and SCLK stay stable for several system clocks around each edge, so that every synchronised edge is seen exactly once. They also assume that chip select never falls in the same cycle as an SCLK edge. The stimulus holds each SCLK phase for six system clocks. It waits several clocks after chip select moves before toggling SCLK. It also leaves a gap of at least ten clocks between frames, which gives the returned word and any write pulse time to settle before the next frame starts. Update strobes and alarm changes occur only in the gaps between frames.

// File: rtl/spi_reg_pkg.sv
// Shared constants and frame layout for the SPI register slave.
package spi_reg_pkg;
    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 6;
    localparam int NREG       = 1 << (ADDR_W - 1);
    localparam int IDX_W      = ADDR_W - 1;
    localparam int DATA_BITS  = 14;

    // Layout of a command frame as received from the master.
    typedef struct packed {
        logic              is_wr;
        logic              must_zero;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } cmd_frame_t;
endpackage

// File: rtl/spi_sync.sv
// Multi-bit synchroniser: a chain of STAGES flops per bit.
// Assumes each bit is an independent slow level; no bus coherence implied.
module spi_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage samples the asynchronous input
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                // later stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
// Bit engine: detects synchronised SCLK / chip-select edges, shifts the
// command in on rising SCLK, shifts the reply out on falling SCLK, and
// reports each frame as complete (exactly FRAME_BITS clocks) or bad.
// Assumes inputs are already synchronised to clk.
module spi_frame_engine
    import spi_reg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk_s,
    input  logic                  cs_s,
    input  logic                  mosi_s,
    input  logic [FRAME_BITS-1:0] tx_word,
    output logic                  miso,
    output logic                  miso_oe,
    output logic [FRAME_BITS-1:0] rx_frame,
    output logic                  frame_ok,
    output logic                  frame_bad
);
    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic                  sclk_d, cs_d;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] tx_sh;
    logic                  sclk_rise, sclk_fall, cs_fall, cs_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_fall   = ~cs_s & cs_d;
    assign cs_rise   = cs_s & ~cs_d;

    // frame sequencing, serial shift in/out and end-of-frame verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d    <= 1'b1;
            cs_d      <= 1'b1;
            cnt       <= '0;
            rx_frame  <= '0;
            tx_sh     <= '0;
            frame_ok  <= 1'b0;
            frame_bad <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            cs_d      <= cs_s;
            frame_ok  <= 1'b0;
            frame_bad <= 1'b0;
            if (cs_fall) begin
                cnt   <= '0;
                tx_sh <= tx_word;
            end else if (!cs_s) begin
                if (sclk_rise) begin
                    rx_frame <= {rx_frame[FRAME_BITS-2:0], mosi_s};
                    if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
                end
                if (sclk_fall && cnt != '0 && cnt < CNT_FULL)
                    tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
            end
            if (cs_rise) begin
                if (cnt == CNT_FULL) frame_ok  <= 1'b1;
                else                 frame_bad <= 1'b1;
            end
        end
    end

    assign miso    = tx_sh[FRAME_BITS-1];
    assign miso_oe = ~cs_s;
endmodule

// File: rtl/spi_reg_access.sv
// Command decoder: turns finished frames into byte writes and pipelined
// 16-bit reads, keeps new-data flags for measurement registers and the
// latched frame-failure flag of the status register.
// Assumes frame_ok / frame_bad are single-cycle and rx_frame is stable then.
module spi_reg_access
    import spi_reg_pkg::*;
#(
    parameter logic [NREG-1:0] DATA_MASK = 32'h0000_00FE,
    parameter logic [NREG-1:0] WR_MASK   = 32'hBFFF_FC00,
    parameter int              STAT_IDX  = 30,
    parameter int              FAIL_BIT  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic                  frame_bad,
    input  logic [FRAME_BITS-1:0] rx_frame,
    input  logic [FRAME_BITS-1:0] rd_data,
    input  logic [NREG-1:0]       upd,
    input  logic                  alarm,
    output logic [IDX_W-1:0]      rd_idx,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic                  wr_hi,
    output logic [7:0]            wr_data,
    output logic [FRAME_BITS-1:0] tx_word
);
    cmd_frame_t            cmd;
    logic [IDX_W-1:0]      idx;
    logic                  is_rd, is_wr, rd_hit;
    logic [NREG-1:0]       nd;
    logic                  fail;
    logic [FRAME_BITS-1:0] word;

    assign cmd    = cmd_frame_t'(rx_frame);
    assign idx    = cmd.addr[ADDR_W-1:1];
    assign is_rd  = ~cmd.is_wr & ~cmd.must_zero;
    assign is_wr  = cmd.is_wr & ~cmd.must_zero;
    assign rd_hit = frame_ok & is_rd;
    assign rd_idx = idx;

    // reply word assembly for the addressed register
    always_comb begin
        word = rd_data;
        if (idx == IDX_W'(STAT_IDX)) begin
            word = '0;
            word[FAIL_BIT] = fail;
        end else if (DATA_MASK[idx]) begin
            word = {nd[idx], alarm, rd_data[DATA_BITS-1:0]};
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_flag
            if (DATA_MASK[g]) begin : g_nd
                // new-data flag: set by update strobe (wins), cleared by read
                always_ff @(posedge clk) begin
                    if (!rst_n)                                  nd[g] <= 1'b0;
                    else if (upd[g])                             nd[g] <= 1'b1;
                    else if (rd_hit && idx == IDX_W'(g))         nd[g] <= 1'b0;
                end
            end else begin : g_none
                assign nd[g] = 1'b0;
            end
        end
    endgenerate

    // latched frame-failure flag, cleared by reading the status register
    always_ff @(posedge clk) begin
        if (!rst_n)                                      fail <= 1'b0;
        else if (frame_bad)                              fail <= 1'b1;
        else if (rd_hit && idx == IDX_W'(STAT_IDX))      fail <= 1'b0;
    end

    // reply staging and byte-write strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_hi   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= frame_ok & is_wr & WR_MASK[idx];
            if (frame_ok) begin
                tx_word <= is_rd ? word : '0;
                wr_idx  <= idx;
                wr_hi   <= cmd.addr[0];
                wr_data <= cmd.data;
            end else if (frame_bad) begin
                tx_word <= '0;
            end
        end
    end
endmodule

// File: rtl/spi_reg_slave.sv
// Top: byte-addressed SPI register slave. Synchronises the SPI pins,
// runs the bit engine and decodes commands toward an external bank.
// Assumes SCLK is much slower than clk (several clocks per phase).
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [NREG-1:0] DATA_MASK   = 32'h0000_00FE,
    parameter logic [NREG-1:0] WR_MASK     = 32'hBFFF_FC00,
    parameter int              STAT_IDX    = 30,
    parameter int              FAIL_BIT    = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sclk,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    output logic                  bank_wr_en,
    output logic [IDX_W-1:0]      bank_wr_idx,
    output logic                  bank_wr_hi,
    output logic [7:0]            bank_wr_data,
    output logic [IDX_W-1:0]      bank_rd_idx,
    input  logic [FRAME_BITS-1:0] bank_rd_data,
    input  logic [NREG-1:0]       data_upd,
    input  logic                  alarm
);
    logic                  sclk_s, cs_s, mosi_s;
    logic [FRAME_BITS-1:0] rx_frame, tx_word;
    logic                  frame_ok, frame_bad;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sclk, spi_cs_n, spi_mosi}),
        .q     ({sclk_s, cs_s, mosi_s})
    );

    spi_frame_engine i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .cs_s      (cs_s),
        .mosi_s    (mosi_s),
        .tx_word   (tx_word),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe),
        .rx_frame  (rx_frame),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad)
    );

    spi_reg_access #(
        .DATA_MASK (DATA_MASK),
        .WR_MASK   (WR_MASK),
        .STAT_IDX  (STAT_IDX),
        .FAIL_BIT  (FAIL_BIT)
    ) i_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad),
        .rx_frame  (rx_frame),
        .rd_data   (bank_rd_data),
        .upd       (data_upd),
        .alarm     (alarm),
        .rd_idx    (bank_rd_idx),
        .wr_en     (bank_wr_en),
        .wr_idx    (bank_wr_idx),
        .wr_hi     (bank_wr_hi),
        .wr_data   (bank_wr_data),
        .tx_word   (tx_word)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Checker for spi_reg_slave: output enable, write strobe shape and
// write legality. Bound into every instance of the top module.
module spi_reg_slave_chk
    import spi_reg_pkg::*;
#(
    parameter logic [NREG-1:0] WR_MASK = 32'hBFFF_FC00
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             miso_oe,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             frame_bad
);
    // R4: chip select high for several cycles means no drive
    assert_oe_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

    // R2: byte write strobe lasts one cycle
    assert_wr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: strobe only toward writable registers
    assert_wr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> WR_MASK[wr_idx]);

    // R6: a discarded frame never yields a write
    assert_bad_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> !wr_en);

    // R1: no write strobe while a frame is still open on the pins
    assert_wr_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !$past(wr_en)) |-> $past(cs_n, 3));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.WR_MASK(WR_MASK)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (spi_cs_n),
    .miso_oe   (spi_miso_oe),
    .wr_en     (bank_wr_en),
    .wr_idx    (bank_wr_idx),
    .frame_bad (frame_bad)
);

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;
    localparam int          NR   = 32;
    localparam logic [31:0] DMSK = 32'h0000_00FE;
    localparam logic [31:0] WMSK = 32'hBFFF_FC00;
    localparam int          STAT = 30;
    localparam int          HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe;
    logic        wr_en, wr_hi;
    logic [4:0]  wr_idx, rd_idx;
    logic [7:0]  wr_data;
    logic [15:0] rd_data;
    logic [31:0] upd = '0;
    logic        alarm = 1'b0;

    logic [15:0] bank   [NR];
    logic [15:0] ro_val [NR];
    logic [15:0] m_bank [NR];
    logic        m_nd   [NR];
    logic        m_fail;
    logic [15:0] exp_next;
    int          wr_cnt = 0, m_wr_cnt = 0;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
        .bank_wr_en(wr_en), .bank_wr_idx(wr_idx), .bank_wr_hi(wr_hi),
        .bank_wr_data(wr_data), .bank_rd_idx(rd_idx), .bank_rd_data(rd_data),
        .data_upd(upd), .alarm(alarm)
    );

    // external register bank written through the byte port
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) bank[i] <= '0;
        end else if (wr_en) begin
            wr_cnt <= wr_cnt + 1;
            if (wr_hi) bank[wr_idx][15:8] <= wr_data;
            else       bank[wr_idx][7:0]  <= wr_data;
        end
    end
    assign rd_data = DMSK[rd_idx] ? ro_val[rd_idx] : bank[rd_idx];

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_frame(input logic [15:0] cmd, input int nbits, output logic [15:0] got);
        got = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = (i < 16) ? cmd[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 16) got[15-i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // expected reply of the following frame and model side effects
    function automatic void model_frame(input logic [15:0] cmd, input int nbits);
        logic [4:0] idx;
        idx = cmd[13:9];
        if (nbits != 16) begin
            m_fail = 1'b1; exp_next = '0;
        end else if (cmd[15:14] == 2'b00) begin
            if (idx == STAT) begin
                exp_next = {12'h0, m_fail, 3'b000}; m_fail = 1'b0;
            end else if (DMSK[idx]) begin
                exp_next = {m_nd[idx], alarm, ro_val[idx][13:0]}; m_nd[idx] = 1'b0;
            end else begin
                exp_next = m_bank[idx];
            end
        end else begin
            if (cmd[15:14] == 2'b10 && WMSK[idx]) begin
                if (cmd[8]) m_bank[idx][15:8] = cmd[7:0];
                else        m_bank[idx][7:0]  = cmd[7:0];
                m_wr_cnt++;
            end
            exp_next = '0;
        end
    endfunction

    task automatic xfer(input logic [15:0] cmd, input int nbits, input string req);
        logic [15:0] got;
        do_frame(cmd, nbits, got);
        if (nbits >= 16) check(req, got, exp_next);
        model_frame(cmd, nbits);
    endtask

    task automatic pulse_upd(input int idx);
        @(negedge clk) upd[idx] = 1'b1;
        @(negedge clk) upd = '0;
        m_nd[idx] = 1'b1;
    endtask

    function automatic logic [15:0] wcmd(input logic [5:0] a, input logic [7:0] d);
        return {2'b10, a, d};
    endfunction
    function automatic logic [15:0] rcmd(input logic [5:0] a);
        return {2'b00, a, 8'h00};
    endfunction

    initial begin
        logic [15:0] got;
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) begin
            ro_val[i] = DMSK[i] ? 16'($urandom) : 16'h0;
            m_bank[i] = '0; m_nd[i] = 1'b0;
        end
        m_fail = 1'b0; exp_next = '0;
        repeat (5) @(negedge clk);
        // R9 reset state
        check("R9 oe", 16'(miso_oe), 16'h0);
        check("R9 wr", 16'(wr_en), 16'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        xfer(rcmd(6'h3C), 16, "R9 first reply");
        // R1 R2 byte writes: odd = upper, even = lower
        xfer(wcmd(6'h15, 8'hA5), 16, "R3 reply");
        check("R2 upper byte", bank[10], 16'hA500);
        xfer(wcmd(6'h14, 8'h3C), 16, "R10 after write");
        check("R2 lower byte", bank[10], 16'hA53C);
        check("R1 write count", 16'(wr_cnt), 16'(m_wr_cnt));
        // R3 read via either address
        xfer(rcmd(6'h15), 16, "R10 after write");
        xfer(rcmd(6'h14), 16, "R3 read upper addr");
        xfer(rcmd(6'h00), 16, "R3 read lower addr");
        // R5 new-data flag and alarm
        pulse_upd(2);
        alarm = 1'b1;
        xfer(rcmd(6'h05), 16, "R3 reply");
        xfer(rcmd(6'h04), 16, "R5 flag set alarm");
        alarm = 1'b0;
        xfer(rcmd(6'h00), 16, "R5 flag cleared");
        // R8 writes to read-only / reserved / status are ignored
        xfer(wcmd(6'h04, 8'hFF), 16, "R3 reply");
        xfer(wcmd(6'h3D, 8'hFF), 16, "R10 reply");
        xfer(wcmd(6'h10, 8'hFF), 16, "R10 reply");
        check("R8 no strobe", 16'(wr_cnt), 16'(m_wr_cnt));
        // R10 bit14 set: no write, zero reply
        xfer(16'hC000 | {2'b00, 6'h17, 8'h77}, 16, "R10 reply");
        check("R10 no write", bank[11], 16'h0000);
        // R6 R7 short and long frames
        xfer(wcmd(6'h17, 8'h11), 9, "R6");
        check("R6 short no write", bank[11], 16'h0000);
        xfer(rcmd(6'h3C), 16, "R6 zero after bad");
        xfer(rcmd(6'h3D), 16, "R7 status set");
        xfer(wcmd(6'h17, 8'h22), 20, "R6 long reply");
        check("R6 long no write", bank[11], 16'h0000);
        xfer(rcmd(6'h3C), 16, "R6 zero after bad");
        xfer(rcmd(6'h00), 16, "R7 status after long");
        xfer(rcmd(6'h00), 16, "R7 status cleared");
        // R4 activity with chip select high is ignored
        for (int i = 0; i < 30; i++) begin
            sclk = ~sclk; mosi = 1'($urandom);
            repeat (3) @(negedge clk);
            if (miso_oe !== 1'b0) check("R4 oe idle", 16'(miso_oe), 16'h0);
        end
        sclk = 1'b1;
        repeat (10) @(negedge clk);
        check("R4 no strobe", 16'(wr_cnt), 16'(m_wr_cnt));
        xfer(rcmd(6'h3C), 16, "R4 reply");
        xfer(rcmd(6'h3C), 16, "R4 no failure latched");

        // constrained random traffic
        for (int n = 0; n < 280; n++) begin
            logic [15:0] cmd;
            int          nb;
            if ($urandom_range(0, 3) == 0) pulse_upd($urandom_range(1, 7));
            alarm = 1'($urandom);
            cmd = 16'($urandom);
            case ($urandom_range(0, 5))
                0, 1: cmd[15:14] = 2'b00;
                2, 3: cmd[15:14] = 2'b10;
                4:    cmd[13:8]  = 6'($urandom_range(2, 15));
                default: ;
            endcase
            nb = ($urandom_range(0, 15) == 0) ? $urandom_range(1, 20) : 16;
            xfer(cmd, nb, "R3 random reply");
            if (nb == 16 && cmd[15:14] == 2'b10) begin
                check("R2 random bank", bank[cmd[13:9]], m_bank[cmd[13:9]]);
                check("R8 random count", 16'(wr_cnt), 16'(m_wr_cnt));
            end
        end
        xfer(rcmd(6'h3C), 16, "R3 final reply");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule